// File: doc/BRIEF.md
# Operating Mode Controller

This block tracks the operating mode of a sensing device and reports it on a 4-bit status code. The host asks for mode changes by writing a 4-bit command code with a one-cycle strobe. Each command is acted on only when the current mode is in that command's own list of legal sources. A command that is not recognised, or that arrives from a mode outside its list, is dropped without effect. Hardware progress comes in on separate inputs:

- a reset-done pulse that takes the block out of its power-up mode;
- a completion pulse that ends offset correction;
- a general event strobe that loads any defined mode code.

The mode encoding is sparse. Memory erase owns two codes, 1101 and 1111, but the block only ever reports 1101. A readback word shows the last accepted command in its top nibble until the requested transition has finished.

Top module: `mode_ctrl`

## Requirements
- R1: While reset is held, and at the first check after it, mode_code is 0000 and cmd_readback is zero.
- R2: In mode 0000, a reset_done pulse moves mode_code to 0010 (OFF) on the next cycle. In any other mode reset_done has no effect.
- R3: Command 0001 moves mode_code to 0001 (offset correction), and it is accepted only from 0010 (OFF) or 0110 (ATR).
- R4: In mode 0001, an offset_done pulse moves mode_code to 0010 on the next cycle. In any other mode offset_done has no effect.
- R5: Command 0010 moves mode_code to 0010, and it is accepted only from 1100 (EXTRACT) or 0110.
- R6: Command 0110 moves mode_code to 0110, and it is accepted only from 0010 or 1100.
- R7: The following leave mode_code and cmd_readback unchanged:
  - any command code other than 0001, 0010 or 0110;
  - a listed command issued from a mode outside its list.
- R8: hw_evt with hw_code in {0000 to 0111, 1100, 1101, 1111} loads that mode on the next cycle. hw_evt with codes 1000 to 1011 or 1110 is ignored.
- R9: cmd_readback behaves as follows:
  - In the cycle after a command is accepted, it holds that code in bits [CODE_LSB+3:CODE_LSB] (15:12 by default), with all other bits zero.
  - It returns to zero one cycle after mode_code reaches the command's final mode (OFF for command 0001), or after a hardware load.
  - A newly accepted command replaces the held code.
- R10: An event with hw_code 1111 yields mode 1101. mode_code never shows 1111.
- R11: Inputs are resolved in this order when they arrive in the same cycle:
  - the current mode's own completion input (reset_done in 0000, offset_done in 0001) comes first;
  - a valid hw_evt comes second;
  - a host command comes last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | One-cycle host command strobe |
| cmd_code | input | 4 | Requested command code |
| reset_done | input | 1 | Power-up sequence finished |
| offset_done | input | 1 | Offset correction finished |
| hw_evt | input | 1 | Hardware mode-load strobe |
| hw_code | input | 4 | Mode code to load on hw_evt |
| mode_code | output | 4 | Current mode status code |
| cmd_readback | output | DATA_W | Command register readback |

## Verification
The bench builds the block with its defaults: DATA_W of 16 and CODE_LSB of 12. With these values the readback nibble lands in bits 15:12, and a check can confirm that the lower twelve bits stay zero. The hardware event input gives direct access to EXTRACT and the other hardware-only modes. This lets every command whitelist be exercised from both its legal and its illegal sources. Same-cycle collisions of completion inputs, events and commands show the priority order.

// File: rtl/mode_pkg.sv
package mode_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    MD_POR     = 4'h0,
    MD_OFS     = 4'h1,
    MD_OFF     = 4'h2,
    MD_DOFS    = 4'h3,
    MD_MPR     = 4'h4,
    MD_SWIPE   = 4'h5,
    MD_ATR     = 4'h6,
    MD_WAKE    = 4'h7,
    MD_EXTRACT = 4'hC,
    MD_ERASE   = 4'hD
  } mode_e;

  localparam logic [CODE_W-1:0] CMD_GO_OFS = 4'h1;
  localparam logic [CODE_W-1:0] CMD_GO_OFF = 4'h2;
  localparam logic [CODE_W-1:0] CMD_GO_ATR = 4'h6;

  typedef struct packed {
    logic  ok;
    mode_e mode;
  } hw_map_t;

  // Whitelist of legal source modes per command
  function automatic logic cmd_allowed(input logic [CODE_W-1:0] code, input mode_e st);
    case (code)
      CMD_GO_OFS: return (st == MD_OFF) || (st == MD_ATR);
      CMD_GO_OFF: return (st == MD_EXTRACT) || (st == MD_ATR);
      CMD_GO_ATR: return (st == MD_OFF) || (st == MD_EXTRACT);
      default:    return 1'b0;
    endcase
  endfunction

  // Mode entered right after acceptance
  function automatic mode_e cmd_dest(input logic [CODE_W-1:0] code);
    case (code)
      CMD_GO_OFS: return MD_OFS;
      CMD_GO_OFF: return MD_OFF;
      CMD_GO_ATR: return MD_ATR;
      default:    return MD_POR;
    endcase
  endfunction

  // Mode at which the requested transition counts as complete
  function automatic mode_e cmd_final(input logic [CODE_W-1:0] code);
    if (code == CMD_GO_OFS) return MD_OFF;
    return cmd_dest(code);
  endfunction

  // Hardware load decode; the duplicate erase code folds onto 1101
  function automatic hw_map_t hw_map(input logic [CODE_W-1:0] code);
    hw_map_t r;
    case (code)
      4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hC, 4'hD: begin
        r.ok   = 1'b1;
        r.mode = mode_e'(code);
      end
      4'hF: begin
        r.ok   = 1'b1;
        r.mode = MD_ERASE;
      end
      default: begin
        r.ok   = 1'b0;
        r.mode = MD_POR;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mode_cmd_decode.sv
module mode_cmd_decode
  import mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CODE_W-1:0] cmd_code,
  input  mode_e             cur_mode,
  output logic              cmd_hit,
  output logic              cmd_ok,
  output mode_e             cmd_tgt
);
  assign cmd_hit = cmd_wr;
  assign cmd_ok  = cmd_wr && cmd_allowed(cmd_code, cur_mode);
  assign cmd_tgt = cmd_dest(cmd_code);

  AST_OK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok |-> (cur_mode == MD_OFF || cur_mode == MD_ATR || cur_mode == MD_EXTRACT)); // R7
  AST_OK_KNOWN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok |-> (cmd_tgt == MD_OFS || cmd_tgt == MD_OFF || cmd_tgt == MD_ATR)); // R7
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_done,
  input  logic              offset_done,
  input  logic              hw_evt,
  input  logic [CODE_W-1:0] hw_code,
  input  logic              cmd_hit,
  input  logic              cmd_ok,
  input  mode_e             cmd_tgt,
  output mode_e             mode,
  output logic              evt_step,
  output logic              hw_load,
  output logic              cmd_take
);
  hw_map_t hwm;
  mode_e   mode_nx;

  assign hwm      = hw_map(hw_code);
  assign evt_step = ((mode == MD_POR) && reset_done) || ((mode == MD_OFS) && offset_done);
  assign hw_load  = hw_evt && hwm.ok && !evt_step;
  assign cmd_take = cmd_ok && !evt_step && !hw_load;

  always_comb begin
    mode_nx = mode;
    if (evt_step)      mode_nx = MD_OFF;
    else if (hw_load)  mode_nx = hwm.mode;
    else if (cmd_take) mode_nx = cmd_tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MD_POR;
    else        mode <= mode_nx;
  end

  AST_POR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_POR && reset_done) |=> mode == MD_OFF); // R2
  AST_OFS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_OFS && offset_done) |=> mode == MD_OFF); // R4
  AST_CMD_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |=> mode == $past(cmd_tgt)); // R3
  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && !cmd_ok && !evt_step && !hw_load) |=> $stable(mode)); // R7
  AST_HW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hw_load |=> mode == $past(hwm.mode)); // R8
  AST_NO_DUP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 4'hF); // R10
  AST_EVT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_step && (hw_evt || cmd_hit)) |=> mode == MD_OFF); // R11
endmodule

// File: rtl/mode_cmd_track.sv
module mode_cmd_track
  import mode_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CODE_LSB = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_take,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              hw_load,
  input  mode_e             mode,
  output logic [DATA_W-1:0] readback
);
  logic [CODE_W-1:0] pend;
  logic              done_hit;

  assign done_hit = (pend != '0) && (mode == cmd_final(pend));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= '0;
    else if (cmd_take) pend <= cmd_code;
    else if (hw_load)  pend <= '0;
    else if (done_hit) pend <= '0;
  end

  always_comb begin
    readback = '0;
    readback[CODE_LSB +: CODE_W] = pend;
  end

  AST_RB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |=> readback == (DATA_W'($past(cmd_code)) << CODE_LSB)); // R9
  AST_RB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_hit || hw_load) && !cmd_take) |=> readback == '0); // R9
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import mode_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CODE_LSB = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [3:0]        cmd_code,
  input  logic              reset_done,
  input  logic              offset_done,
  input  logic              hw_evt,
  input  logic [3:0]        hw_code,
  output logic [3:0]        mode_code,
  output logic [DATA_W-1:0] cmd_readback
);
  mode_e mode;
  mode_e cmd_tgt;
  logic  cmd_hit, cmd_ok, evt_step, hw_load, cmd_take;

  mode_cmd_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .cmd_code (cmd_code),
    .cur_mode (mode),
    .cmd_hit  (cmd_hit),
    .cmd_ok   (cmd_ok),
    .cmd_tgt  (cmd_tgt)
  );

  mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .reset_done  (reset_done),
    .offset_done (offset_done),
    .hw_evt      (hw_evt),
    .hw_code     (hw_code),
    .cmd_hit     (cmd_hit),
    .cmd_ok      (cmd_ok),
    .cmd_tgt     (cmd_tgt),
    .mode        (mode),
    .evt_step    (evt_step),
    .hw_load     (hw_load),
    .cmd_take    (cmd_take)
  );

  mode_cmd_track #(.DATA_W(DATA_W), .CODE_LSB(CODE_LSB)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_take (cmd_take),
    .cmd_code (cmd_code),
    .hw_load  (hw_load),
    .mode     (mode),
    .readback (cmd_readback)
  );

  assign mode_code = mode;
endmodule

// File: tb/test_mode_ctrl.sv
module test_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [3:0]  cmd_code = '0;
  logic        reset_done = 1'b0;
  logic        offset_done = 1'b0;
  logic        hw_evt = 1'b0;
  logic [3:0]  hw_code = '0;
  logic [3:0]  mode_code;
  logic [15:0] cmd_readback;

  int n_chk  = 0;
  int n_fail = 0;
  bit saw_f  = 1'b0;

  always #4 clk = ~clk;

  mode_ctrl i_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .reset_done(reset_done), .offset_done(offset_done),
    .hw_evt(hw_evt), .hw_code(hw_code),
    .mode_code(mode_code), .cmd_readback(cmd_readback)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  code;
    logic        rd;
    logic        od;
    logic        hv;
    logic [3:0]  hc;
    logic [3:0]  em;
    logic [15:0] erb;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 16'h0000, 4'd1},  // R1 idle in POR
    '{1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'h0, 4'h0, 16'h0000, 4'd4},  // R4 offset_done outside 0001
    '{1'b1, 4'h1, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 16'h0000, 4'd7},  // R7 cmd from POR
    '{1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 4'h2, 16'h0000, 4'd2},  // R2
    '{1'b1, 4'h2, 1'b0, 1'b0, 1'b0, 4'h0, 4'h2, 16'h0000, 4'd7},  // R7 OFF cmd from OFF
    '{1'b1, 4'h1, 1'b0, 1'b0, 1'b0, 4'h0, 4'h1, 16'h1000, 4'd3},  // R3 from OFF
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 4'h1, 16'h1000, 4'd9},  // R9 held
    '{1'b1, 4'h6, 1'b0, 1'b0, 1'b0, 4'h0, 4'h1, 16'h1000, 4'd7},  // R7 ATR from 0001
    '{1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'h0, 4'h2, 16'h1000, 4'd4},  // R4
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 4'h2, 16'h0000, 4'd9},  // R9 clears
    '{1'b1, 4'h6, 1'b0, 1'b0, 1'b0, 4'h0, 4'h6, 16'h6000, 4'd6},  // R6 from OFF
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 4'h6, 16'h0000, 4'd9},  // R9
    '{1'b1, 4'h1, 1'b0, 1'b0, 1'b0, 4'h0, 4'h1, 16'h1000, 4'd3},  // R3 from ATR
    '{1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'h0, 4'h2, 16'h1000, 4'd4},  // R4
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 4'h2, 16'h0000, 4'd9},  // R9
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 4'hC, 4'hC, 16'h0000, 4'd8},  // R8 to EXTRACT
    '{1'b1, 4'h1, 1'b0, 1'b0, 1'b0, 4'h0, 4'hC, 16'h0000, 4'd7},  // R7 0001 from EXTRACT
    '{1'b1, 4'h6, 1'b0, 1'b0, 1'b0, 4'h0, 4'h6, 16'h6000, 4'd6},  // R6 from EXTRACT
    '{1'b1, 4'h2, 1'b0, 1'b0, 1'b0, 4'h0, 4'h2, 16'h2000, 4'd5},  // R5 from ATR, replaces
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 4'h2, 16'h0000, 4'd9},  // R9
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 4'hC, 4'hC, 16'h0000, 4'd8},  // R8
    '{1'b1, 4'h2, 1'b0, 1'b0, 1'b0, 4'h0, 4'h2, 16'h2000, 4'd5},  // R5 from EXTRACT
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 4'h9, 4'h2, 16'h0000, 4'd8},  // R8 undefined code
    '{1'b1, 4'h3, 1'b0, 1'b0, 1'b0, 4'h0, 4'h2, 16'h0000, 4'd7},  // R7 unlisted code
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 4'hF, 4'hD, 16'h0000, 4'd10}, // R10 fold 1111
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 4'h5, 4'h5, 16'h0000, 4'd8},  // R8
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 4'h2, 4'h2, 16'h0000, 4'd8},  // R8
    '{1'b1, 4'h6, 1'b0, 1'b0, 1'b1, 4'h7, 4'h7, 16'h0000, 4'd11}, // R11 event beats cmd
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 4'h2, 4'h2, 16'h0000, 4'd8},  // R8
    '{1'b1, 4'h1, 1'b0, 1'b0, 1'b0, 4'h0, 4'h1, 16'h1000, 4'd3},  // R3
    '{1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 4'h6, 4'h2, 16'h1000, 4'd11}, // R11 done beats event
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 4'h2, 16'h0000, 4'd9},  // R9
    '{1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 4'h2, 16'h0000, 4'd2},  // R2 reset_done outside POR
    '{1'b1, 4'h1, 1'b0, 1'b0, 1'b0, 4'h0, 4'h1, 16'h1000, 4'd3},  // R3
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 4'hD, 4'hD, 16'h0000, 4'd9},  // R9 hw load clears
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 4'hE, 4'hD, 16'h0000, 4'd8},  // R8 undefined 1110
    '{1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 4'h0, 4'h0, 16'h0000, 4'd8},  // R8 back to POR
    '{1'b0, 4'h0, 1'b1, 1'b0, 1'b1, 4'h6, 4'h2, 16'h0000, 4'd11}  // R11 reset_done beats event
  };

  task automatic check(input string tag, input logic [3:0] em, input logic [15:0] erb);
    n_chk++;
    if (mode_code !== em || cmd_readback !== erb) begin
      n_fail++;
      $display("FAIL %s: mode=%h readback=%h expected mode=%h readback=%h",
               tag, mode_code, cmd_readback, em, erb);
    end
  endtask

  always @(negedge clk) if (rst_n && mode_code == 4'hF) saw_f = 1'b1;

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset", 4'h0, 16'h0000);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      cmd_wr      = VECS[i].wr;
      cmd_code    = VECS[i].code;
      reset_done  = VECS[i].rd;
      offset_done = VECS[i].od;
      hw_evt      = VECS[i].hv;
      hw_code     = VECS[i].hc;
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].em, VECS[i].erb);
    end
    cmd_wr = 0; reset_done = 0; offset_done = 0; hw_evt = 0;
    // R1: reset in the middle of a pending offset correction
    reset_done = 1; @(negedge clk); reset_done = 0;
    cmd_wr = 1; cmd_code = 4'h1; @(negedge clk); cmd_wr = 0;
    check("R3 before reset", 4'h1, 16'h1000);
    rst_n = 1'b0; @(negedge clk);
    check("R1 mid-run reset", 4'h0, 16'h0000);
    rst_n = 1'b1; @(negedge clk);
    check("R1 after release", 4'h0, 16'h0000);
    // R10: 1111 never observed
    n_chk++;
    if (saw_f) begin
      n_fail++;
      $display("FAIL R10: mode 1111 observed, expected never");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule